// File: doc/BRIEF.md
# Area Sensor Readout Timing Generator

This block sequences the readout of a 32x32 pixel area sensor in continuous 2D output mode. It runs from a single clock. Two setting words set the timing: a 4-bit pixel-rate code and a 16-bit exposure length. Both words are captured together when a load strobe is high. From them the block derives three periods:

- the clocks per pixel (the data output cycle, DOC),
- the clocks per line,
- the lines per frame.

It drives four outputs:

- a pixel strobe, once per DOC,
- single-clock line-start and frame-start markers,
- an exposure window that closes exactly at the frame boundary.

Loaded settings wait in a holding stage. They become active only at the start of the next frame, so a frame never changes geometry while it is running. A start input moves the block from idle to running. Once running, it produces frames back to back until a synchronous reset returns it to idle.

Top module: `rtg_top`

## Requirements
- R1: After reset, and until start is sampled high, pixStb, lineStart, frameStart and accWin stay low. This holds even if load pulses arrive during that time.
- R2: When start is sampled high while idle, frameStart is high in the following clock. A start pulse while running has no effect on the timing.
- R3: drIn is an unsigned code with bit 3 as the MSB. The pixel period is DOC = (drIn+1)×4 clocks, so codes 0 to 15 give 4 to 64 clocks. Within a line, consecutive pixel strobes are exactly DOC clocks apart.
- R4: Each line lasts 38 + 32×DOC clocks. lineStart is high in its first clock. The first 38 clocks carry no pixel strobe. The first strobe is at clock offset 38, and each line carries exactly 32 strobes.
- R5: When the active exposure value is 0x001E or less, a frame lasts 33 lines.
- R6: When the active exposure value is 0x001F or more, a frame lasts (value + 2) lines.
- R7: In each frame, accWin is high for exactly value × line-period clocks in one contiguous run. It rises with a lineStart and is high in the frame's last clock. It is never high when the value is 0.
- R8: frameStart is high for exactly one clock, and always together with lineStart.
- R9: Values loaded during a frame do not change that frame. They take effect from the next frameStart onward.
- R10: A synchronous reset while running returns the block to idle with zeroed settings. A later start then runs with drIn=0 timing, that is, a 166-clock line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Start request; begins frames when the block is idle |
| loadReq | input | 1 | Captures drIn and accIn into the holding stage |
| drIn | input | 4 | Pixel-rate code |
| accIn | input | 16 | Exposure length, in lines |
| pixStb | output | 1 | Pixel data strobe, one clock wide |
| lineStart | output | 1 | First clock of each line |
| frameStart | output | 1 | First clock of each frame |
| accWin | output | 1 | Exposure window |

## Verification
The assertions check the following on every clock:
- the single-clock shape of frameStart and its pairing with lineStart,
- the absence of a pixel strobe in a line's first clock,
- the minimum gap between pixel strobes,
- the edges of accWin against line and frame boundaries,
- the one-clock latency from start to the first frame.

Only the bench scenarios can show the counted quantities. These are the exact line and frame lengths, the strobe positions, the exposure clock totals, the 33-line floor against the value+2 rule, and deferred loading across a frame boundary. The bench measures these from the ports over whole frames.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef struct packed {
    logic run;    // block is producing frames
    logic latch;  // counters restart; new settings become active
  } rtgCtl_t;
endpackage

// File: rtl/rtg_geometry.sv
module rtg_geometry #(
  parameter int DR_W      = 4,
  parameter int ACC_W     = 16,
  parameter int DOC_STEP  = 4,
  parameter int PIX_LINE  = 32,
  parameter int OVH_CLKS  = 38,
  parameter int MIN_LINES = 33,
  localparam int DOC_W  = $clog2((2**DR_W) * DOC_STEP + 1),
  localparam int LINE_W = $clog2(OVH_CLKS + PIX_LINE * (2**DR_W) * DOC_STEP + 1),
  localparam int LCNT_W = ACC_W + 1
) (
  input  logic [DR_W-1:0]   activeDr,
  input  logic [ACC_W-1:0]  activeAcc,
  output logic [DOC_W-1:0]  docVal,
  output logic [LINE_W-1:0] linePeriod,
  output logic [LCNT_W-1:0] frameLines,
  output logic [LCNT_W-1:0] accFirstLine
);
  localparam int SHORT_MAX = MIN_LINES - 3;

  logic [DOC_W-1:0]  codePlusOne;
  logic [LCNT_W-1:0] accWide;

  assign codePlusOne = DOC_W'(activeDr) + DOC_W'(1);
  assign docVal      = codePlusOne * DOC_W'(DOC_STEP);
  assign linePeriod  = LINE_W'(OVH_CLKS) + LINE_W'(PIX_LINE) * LINE_W'(docVal);
  assign accWide     = LCNT_W'(activeAcc);

  always_comb begin
    if (activeAcc <= ACC_W'(SHORT_MAX)) frameLines = LCNT_W'(MIN_LINES);
    else                                frameLines = accWide + LCNT_W'(2);
  end

  assign accFirstLine = frameLines - accWide;
endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
#(
  parameter int DR_W  = 4,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             loadReq,
  input  logic [DR_W-1:0]  drIn,
  input  logic [ACC_W-1:0] accIn,
  input  logic             frameEnd,
  output rtgCtl_t          ctl,
  output logic [DR_W-1:0]  activeDr,
  output logic [ACC_W-1:0] activeAcc
);
  logic             running;
  logic [DR_W-1:0]  pendDr;
  logic [ACC_W-1:0] pendAcc;
  logic             goNow;
  logic             latchNow;

  assign goNow    = startReq && !running;
  assign latchNow = goNow || frameEnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      pendDr    <= '0;
      pendAcc   <= '0;
      activeDr  <= '0;
      activeAcc <= '0;
    end else begin
      if (goNow) running <= 1'b1;
      if (loadReq) begin
        pendDr  <= drIn;
        pendAcc <= accIn;
      end
      if (latchNow) begin
        activeDr  <= loadReq ? drIn  : pendDr;
        activeAcc <= loadReq ? accIn : pendAcc;
      end
    end
  end

  assign ctl.run   = running;
  assign ctl.latch = latchNow;
endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
#(
  parameter int DR_W      = 4,
  parameter int ACC_W     = 16,
  parameter int DOC_STEP  = 4,
  parameter int PIX_LINE  = 32,
  parameter int OVH_CLKS  = 38,
  parameter int MIN_LINES = 33,
  localparam int DOC_W  = $clog2((2**DR_W) * DOC_STEP + 1),
  localparam int LINE_W = $clog2(OVH_CLKS + PIX_LINE * (2**DR_W) * DOC_STEP + 1),
  localparam int LCNT_W = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  rtgCtl_t          ctl,
  input  logic [DR_W-1:0]  activeDr,
  input  logic [ACC_W-1:0] activeAcc,
  output logic             pixStb,
  output logic             lineStart,
  output logic             frameStart,
  output logic             accWin,
  output logic             frameEnd
);
  logic [DOC_W-1:0]  docVal;
  logic [LINE_W-1:0] linePeriod;
  logic [LCNT_W-1:0] frameLines;
  logic [LCNT_W-1:0] accFirstLine;

  logic [LINE_W-1:0] clkCnt;
  logic [LCNT_W-1:0] lineCnt;
  logic [DOC_W-1:0]  phase;
  logic              lastClk;
  logic              lastLine;
  logic              inPixel;

  rtg_geometry #(
    .DR_W(DR_W), .ACC_W(ACC_W), .DOC_STEP(DOC_STEP), .PIX_LINE(PIX_LINE),
    .OVH_CLKS(OVH_CLKS), .MIN_LINES(MIN_LINES)
  ) u_geom (
    .activeDr    (activeDr),
    .activeAcc   (activeAcc),
    .docVal      (docVal),
    .linePeriod  (linePeriod),
    .frameLines  (frameLines),
    .accFirstLine(accFirstLine)
  );

  assign lastClk  = (clkCnt == linePeriod - LINE_W'(1));
  assign lastLine = (lineCnt == frameLines - LCNT_W'(1));
  assign inPixel  = (clkCnt >= LINE_W'(OVH_CLKS));
  assign frameEnd = ctl.run && lastClk && lastLine;

  always_ff @(posedge clk) begin
    if (rst || !ctl.run || ctl.latch) begin
      clkCnt  <= '0;
      lineCnt <= '0;
      phase   <= '0;
    end else begin
      if (lastClk) begin
        clkCnt  <= '0;
        lineCnt <= lineCnt + LCNT_W'(1);
      end else begin
        clkCnt <= clkCnt + LINE_W'(1);
      end
      if (!inPixel || phase == docVal - DOC_W'(1)) phase <= '0;
      else                                          phase <= phase + DOC_W'(1);
    end
  end

  assign pixStb     = ctl.run && inPixel && (phase == '0);
  assign lineStart  = ctl.run && (clkCnt == '0);
  assign frameStart = lineStart && (lineCnt == '0);
  assign accWin     = ctl.run && (activeAcc != '0) && (lineCnt >= accFirstLine);
endmodule

// File: rtl/rtg_top.sv
module rtg_top
  import rtg_pkg::*;
#(
  parameter int DR_W      = 4,
  parameter int ACC_W     = 16,
  parameter int DOC_STEP  = 4,
  parameter int PIX_LINE  = 32,
  parameter int OVH_CLKS  = 38,
  parameter int MIN_LINES = 33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             loadReq,
  input  logic [DR_W-1:0]  drIn,
  input  logic [ACC_W-1:0] accIn,
  output logic             pixStb,
  output logic             lineStart,
  output logic             frameStart,
  output logic             accWin
);
  rtgCtl_t          ctl;
  logic [DR_W-1:0]  activeDr;
  logic [ACC_W-1:0] activeAcc;
  logic             frameEnd;
  logic             runNow;

  assign runNow = ctl.run;

  rtg_ctrl #(.DR_W(DR_W), .ACC_W(ACC_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .loadReq  (loadReq),
    .drIn     (drIn),
    .accIn    (accIn),
    .frameEnd (frameEnd),
    .ctl      (ctl),
    .activeDr (activeDr),
    .activeAcc(activeAcc)
  );

  rtg_datapath #(
    .DR_W(DR_W), .ACC_W(ACC_W), .DOC_STEP(DOC_STEP), .PIX_LINE(PIX_LINE),
    .OVH_CLKS(OVH_CLKS), .MIN_LINES(MIN_LINES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .activeDr  (activeDr),
    .activeAcc (activeAcc),
    .pixStb    (pixStb),
    .lineStart (lineStart),
    .frameStart(frameStart),
    .accWin    (accWin),
    .frameEnd  (frameEnd)
  );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker (
  input logic clk,
  input logic rst,
  input logic run,
  input logic startReq,
  input logic pixStb,
  input logic lineStart,
  input logic frameStart,
  input logic accWin
);
  p_first_frame_r2: assert property (@(posedge clk) disable iff (rst)
    (startReq && !run) |=> frameStart);

  p_fs_single_r8: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart);

  p_fs_with_ls_r8: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> lineStart);

  p_ls_no_pix_r4: assert property (@(posedge clk) disable iff (rst)
    lineStart |-> !pixStb);

  p_pix_gap_r3: assert property (@(posedge clk) disable iff (rst)
    pixStb |=> !pixStb);

  p_acc_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(accWin) |-> frameStart);

  p_acc_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(accWin) |-> lineStart);
endmodule

bind rtg_top rtg_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (runNow),
  .startReq  (startReq),
  .pixStb    (pixStb),
  .lineStart (lineStart),
  .frameStart(frameStart),
  .accWin    (accWin)
);

// File: tb/rtg_top_tb.sv
`timescale 1ns/1ps
module rtg_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startReq = 1'b0;
  logic        loadReq = 1'b0;
  logic [3:0]  drIn = '0;
  logic [15:0] accIn = '0;
  logic        pixStb, lineStart, frameStart, accWin;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int seed   = 32'h5eed_1234;

  always #2.5 clk = ~clk;

  rtg_top u_dut (
    .clk(clk), .rst(rst), .startReq(startReq), .loadReq(loadReq),
    .drIn(drIn), .accIn(accIn), .pixStb(pixStb), .lineStart(lineStart),
    .frameStart(frameStart), .accWin(accWin)
  );

  function automatic int docOf(int dr);
    return (dr + 1) * 4;
  endfunction
  function automatic int linePerOf(int dr);
    return 38 + 32 * docOf(dr);
  endfunction
  function automatic int linesOf(int acc);
    return (acc <= 30) ? 33 : acc + 2;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Called at a negedge where frameStart is high; returns at the next one.
  task automatic measureFrame(input int dr, input int acc);
    int clks = 0, lines = 0, pix = 0, accCnt = 0, posBad = 0;
    int lastLs = 0, pixInLine = 0;
    bit accPrev = 0;
    int lp = linePerOf(dr);
    int nl = linesOf(acc);
    string lenTag = (acc <= 30) ? "R5 frame lines" : "R6 frame lines";
    do begin
      if (lineStart) begin lines++; lastLs = clks; pixInLine = 0; end
      if (pixStb) begin
        if (clks - lastLs != 38 + pixInLine * docOf(dr)) posBad++;
        pixInLine++; pix++;
      end
      accCnt += accWin;
      accPrev = accWin;
      clks++;
      @(negedge clk);
    end while (!frameStart && clks < 100000);
    check(lines == nl, lenTag, lines, nl);
    check(clks == lp * nl, "R4 frame clocks", clks, lp * nl);
    check(pix == 32 * nl, "R4 strobes per frame", pix, 32 * nl);
    check(posBad == 0, "R3 strobe positions", posBad, 0);
    check(accCnt == acc * lp, "R7 exposure clocks", accCnt, acc * lp);
    check(accPrev == (acc != 0), "R7 window at frame end", accPrev, acc != 0);
  endtask

  // Called at a negedge where lineStart is high.
  task automatic measureLine(input int dr, input string tag);
    int clks = 0, pix = 0, firstOff = -1;
    do begin
      if (pixStb) begin if (firstOff < 0) firstOff = clks; pix++; end
      clks++;
      @(negedge clk);
    end while (!lineStart && clks < 5000);
    check(clks == linePerOf(dr), {tag, " line period"}, clks, linePerOf(dr));
    check(pix == 32, {tag, " strobes per line"}, pix, 32);
    check(firstOff == 38, {tag, " first strobe offset"}, firstOff, 38);
  endtask

  task automatic loadLater(input int dr, input int acc, input bit alsoStart);
    repeat (40) @(negedge clk);
    loadReq = 1'b1; drIn = 4'(dr); accIn = 16'(acc);
    if (alsoStart) startReq = 1'b1;
    @(negedge clk);
    loadReq = 1'b0; startReq = 1'b0;
    drIn = 4'($urandom); accIn = 16'($urandom);
  endtask

  task automatic frameThenNext(input int cd, input int ca, input int nd, input int na, input bit st);
    fork
      measureFrame(cd, ca);
      loadLater(nd, na, st);
    join
  endtask

  initial begin
    int bad;
    int curD, curA, nd, na;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: idle after reset, loads do not start anything
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (i == 5) begin loadReq = 1'b1; drIn = 4'd3; accIn = 16'd7; end
      if (i == 6) loadReq = 1'b0;
      if (pixStb || lineStart || frameStart || accWin) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R1 idle outputs", bad, 0);

    // Configure (0,0) then start; R2 first frameStart one clock later
    loadReq = 1'b1; drIn = 4'd0; accIn = 16'd0;
    @(negedge clk);
    loadReq = 1'b0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(frameStart == 1'b1, "R2 first frameStart", frameStart, 1);
    check(lineStart == 1'b1, "R8 frameStart with lineStart", lineStart, 1);

    // R9 deferred load and R2 start ignored while running
    frameThenNext(0, 0, 0, 30, 1'b1);
    frameThenNext(0, 30, 0, 31, 1'b0);  // R5 boundary 0x1E
    frameThenNext(0, 31, 1, 32, 1'b0);  // R6 boundary 0x1F
    curD = 1; curA = 32;
    for (int k = 0; k < 3; k++) begin
      nd = $urandom % 3;
      na = $urandom % 41;
      frameThenNext(curD, curA, nd, na, 1'b0);
      curD = nd; curA = na;
    end
    frameThenNext(curD, curA, 15, 1, 1'b0);

    // R3 slowest rate: 64 clocks per pixel
    measureLine(15, "R3");

    // R10 reset mid-run
    repeat (300) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (pixStb || lineStart || frameStart || accWin) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R10 idle after reset", bad, 0);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(frameStart == 1'b1, "R10 restart frameStart", frameStart, 1);
    measureLine(0, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule